// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a four-bit counter that steps up on one strobe and down on another. Either strobe only counts while the other is held high. A parameter sets the modulus: decade (0 to 9) or full binary (0 to 15). A clear input forces the count to zero. An active-low load input copies a four-bit parallel value into the count. Both of these are level controls, and they override counting.

Two active-low terminal flags, carry and borrow, let stages be chained with no glue logic. Carry pulls low while the up strobe is low and the count sits at its top value. Borrow pulls low while the down strobe is low and the count is zero. Wiring carry to the next stage's up strobe and borrow to its down strobe makes a multi-digit counter. The flag's return to high acts as the next stage's count edge.

Everything runs on one fast system clock. Both strobes pass through a two-flop synchronizer, and their rising edges are detected on the synchronized level. A count edge therefore reaches the count output on the third system clock edge after the strobe rises.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `clr` is high, the count becomes 0 on the next system clock. This takes priority over load and over any strobe edge.
- R2: While `load_n` is low and `clr` is low, the count takes `load_val` on the next system clock. This takes priority over any strobe edge.
- R3: A rising edge on `up_strb` while `dn_strb` is high raises the count by one.
- R4: A rising edge on `dn_strb` while `up_strb` is high lowers the count by one.
- R5: A rising edge on either strobe while the other strobe is low leaves the count unchanged.
- R6: Counting wraps. In decade mode, an up step from 9 gives 0 and a down step from 0 gives 9. In binary mode, 15 up gives 0 and 0 down gives 15.
- R7: `carry_n` is low exactly when the synchronized `up_strb` is low and the count equals the top value (9 in decade mode, 15 in binary mode). Otherwise it is high.
- R8: `borrow_n` is low exactly when the synchronized `dn_strb` is low and the count is 0. Otherwise it is high.
- R9: In decade mode, a load value above 9 is held as given. An up step from any value of 9 or more gives 0. A down step from a value above 9 lowers it by one.
- R10: Rising edges on both strobes in the same synchronized cycle leave the count unchanged.
- R11: Two decade stages chained carry-to-up and borrow-to-down form a two-digit counter. The upper digit steps once each time the lower digit wraps in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Master clear, level-sensitive, active high |
| load_n | input | 1 | Parallel load enable, active low |
| load_val | input | WIDTH | Parallel load value |
| up_strb | input | 1 | Count-up strobe, counts on its rising edge |
| dn_strb | input | 1 | Count-down strobe, counts on its rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal flag for counting up |
| borrow_n | output | 1 | Active-low terminal flag for counting down |

## Verification
The hardest behaviour to reach from the ports is a count from an upper digit in a chain. That stage only moves when the lower stage's flag returns high, which needs the lower stage at its terminal value during the low phase of a strobe. The bench chains a second decade stage behind the device under test. It then drives long runs of up and down strobe pulses, so the lower digit wraps many times in both directions.

A second pattern of stimulus covers edges that must be ignored. It lowers the other strobe first, or lowers both strobes together, and then raises them.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_INC   = 3'd1,
    ACT_DEC   = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_CLEAR = 3'd4
  } cnt_act_e;

  localparam int STRB_UP = 0;
  localparam int STRB_DN = 1;
  localparam int NUM_STRB = 2;
endpackage

// File: rtl/dsc_strobe_sync.sv
`timescale 1ns/1ps
module dsc_strobe_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain [N];
  logic [N-1:0]      prev;

  for (genvar g = 0; g < N; g++) begin : g_strb
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[g] <= '1;
        prev[g]  <= 1'b1;
      end else begin
        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        prev[g]  <= chain[g][LAST];
      end
    end
    assign level[g] = chain[g][LAST];
    assign rise[g]  = chain[g][LAST] & ~prev[g];
  end

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));  // R3
endmodule

// File: rtl/dsc_action_sel.sv
`timescale 1ns/1ps
module dsc_action_sel
  import dsc_pkg::*;
(
  input  logic                clr,
  input  logic                load_n,
  input  logic [NUM_STRB-1:0] level,
  input  logic [NUM_STRB-1:0] rise,
  output cnt_act_e            act
);
  logic inc_ok, dec_ok;

  assign inc_ok = rise[STRB_UP] & level[STRB_DN];
  assign dec_ok = rise[STRB_DN] & level[STRB_UP];

  always_comb begin
    if (clr)                  act = ACT_CLEAR;
    else if (!load_n)         act = ACT_LOAD;
    else if (inc_ok && dec_ok) act = ACT_HOLD;
    else if (inc_ok)          act = ACT_INC;
    else if (dec_ok)          act = ACT_DEC;
    else                      act = ACT_HOLD;
  end
endmodule

// File: rtl/dsc_count_core.sv
`timescale 1ns/1ps
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (act)
        ACT_CLEAR: cnt <= '0;
        ACT_LOAD:  cnt <= load_val;
        ACT_INC:   cnt <= (cnt >= TOP) ? '0 : cnt + WIDTH'(1);
        ACT_DEC:   cnt <= (cnt == '0) ? TOP : cnt - WIDTH'(1);
        default:   cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dsc_term_flags.sv
`timescale 1ns/1ps
module dsc_term_flags #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic [WIDTH-1:0] cnt,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  assign carry_n  = ~(~up_lvl & (cnt == TOP));
  assign borrow_n = ~(~dn_lvl & (cnt == '0));
endmodule

// File: rtl/dual_strobe_counter.sv
`timescale 1ns/1ps
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             up_strb,
  input  logic             dn_strb,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [NUM_STRB-1:0] raw, level, rise;
  cnt_act_e            act;

  assign raw[STRB_UP] = up_strb;
  assign raw[STRB_DN] = dn_strb;

  dsc_strobe_sync #(.N(NUM_STRB), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(raw), .level(level), .rise(rise)
  );

  dsc_action_sel u_act (
    .clr(clr), .load_n(load_n), .level(level), .rise(rise), .act(act)
  );

  dsc_count_core #(.WIDTH(WIDTH), .DECADE(DECADE)) u_core (
    .clk(clk), .rst(rst), .act(act), .load_val(load_val), .cnt(count)
  );

  dsc_term_flags #(.WIDTH(WIDTH), .DECADE(DECADE)) u_flags (
    .up_lvl(level[STRB_UP]), .dn_lvl(level[STRB_DN]), .cnt(count),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));  // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(load_val)));  // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n) |=> (count == $past(count) ||
                          count == (($past(count) >= TOP) ? '0 : $past(count) + WIDTH'(1)) ||
                          count == (($past(count) == '0) ? TOP : $past(count) - WIDTH'(1))));  // R6
  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count == TOP));  // R7
  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count == '0));  // R8
  AST_NO_COUNT_WHEN_OTHER_LOW: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && !up_strb && !dn_strb && !level[STRB_UP] && !level[STRB_DN]) |=> $stable(count));  // R5
endmodule

// File: tb/dual_strobe_counter_test.sv
`timescale 1ns/1ps
module dual_strobe_counter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, clr, load_n, up, dn;
  logic [3:0] load_val;
  logic [3:0] c_bcd, c_bin, c_hi;
  logic       cy_bcd, bw_bcd, cy_bin, bw_bin, cy_hi, bw_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int e_bcd, e_bin, e_hi;

  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .load_val(load_val),
    .up_strb(up), .dn_strb(dn), .count(c_bcd), .carry_n(cy_bcd), .borrow_n(bw_bcd)
  );
  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_STAGES(2)) uut_bin (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .load_val(load_val),
    .up_strb(up), .dn_strb(dn), .count(c_bin), .carry_n(cy_bin), .borrow_n(bw_bin)
  );
  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) uut_hi (
    .clk(clk), .rst(rst), .clr(clr), .load_n(1'b1), .load_val(4'd0),
    .up_strb(cy_bcd), .dn_strb(bw_bcd), .count(c_hi), .carry_n(cy_hi), .borrow_n(bw_hi)
  );

  function automatic int bcd_inc(int v); return (v >= 9) ? 0 : v + 1; endfunction
  function automatic int bcd_dec(int v); return (v == 0) ? 9 : v - 1; endfunction
  function automatic int bin_inc(int v); return (v + 1) % 16; endfunction
  function automatic int bin_dec(int v); return (v + 15) % 16; endfunction

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_counts(string tag);
    chk({tag, " bcd count"}, int'(c_bcd), e_bcd);
    chk({tag, " bin count"}, int'(c_bin), e_bin);
    chk({"R11 ", tag, " upper digit"}, int'(c_hi), e_hi);
  endtask

  task automatic pulse_up();
    up = 1'b0;
    waitn(6);
    chk("R7 carry bcd", int'(cy_bcd), (e_bcd == 9) ? 0 : 1);
    chk("R7 carry bin", int'(cy_bin), (e_bin == 15) ? 0 : 1);
    chk("R8 borrow idle", int'(bw_bcd), 1);
    up = 1'b1;
    if (e_bcd == 9) e_hi = bcd_inc(e_hi);
    e_bcd = bcd_inc(e_bcd);
    e_bin = bin_inc(e_bin);
    waitn(6);
    chk_counts("R3/R6 up");
  endtask

  task automatic pulse_dn();
    dn = 1'b0;
    waitn(6);
    chk("R8 borrow bcd", int'(bw_bcd), (e_bcd == 0) ? 0 : 1);
    chk("R8 borrow bin", int'(bw_bin), (e_bin == 0) ? 0 : 1);
    chk("R7 carry idle", int'(cy_bcd), 1);
    dn = 1'b1;
    if (e_bcd == 0) e_hi = bcd_dec(e_hi);
    e_bcd = bcd_dec(e_bcd);
    e_bin = bin_dec(e_bin);
    waitn(6);
    chk_counts("R4/R6 down");
  endtask

  task automatic preset(int v);
    load_val = 4'(v);
    load_n = 1'b0;
    waitn(3);
    load_n = 1'b1;
    e_bcd = v;
    e_bin = v;
    waitn(1);
    chk("R2 R9 load bcd", int'(c_bcd), v);
    chk("R2 load bin", int'(c_bin), v);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; load_n = 1'b1; load_val = 4'd0; up = 1'b1; dn = 1'b1;
    e_bcd = 0; e_bin = 0; e_hi = 0;
    waitn(4);
    rst = 1'b0;
    waitn(2);
    chk_counts("R1 reset");
    chk("R7 reset carry", int'(cy_bcd), 1);
    chk("R8 reset borrow", int'(bw_bcd), 1);

    // R3 R6 R11: up sweep with several wraps
    for (int i = 0; i < 25; i++) pulse_up();
    // R4 R6 R11: down sweep crossing zero repeatedly
    for (int i = 0; i < 32; i++) pulse_dn();

    // R2 R9 R6: every load value, then one step each way
    for (int v = 0; v < 16; v++) begin
      preset(v);
      pulse_up();
      preset(v);
      pulse_dn();
    end

    // R5: up edge while down held low, then down edge while up held low
    preset(5);
    dn = 1'b0; waitn(6);
    up = 1'b0; waitn(6);
    up = 1'b1; waitn(6);
    chk("R5 up ignored bcd", int'(c_bcd), 5);
    chk("R5 up ignored bin", int'(c_bin), 5);
    dn = 1'b1; waitn(6);
    e_bcd = 4; e_bin = 4;
    chk_counts("R4 down after up");
    up = 1'b0; waitn(6);
    dn = 1'b0; waitn(6);
    dn = 1'b1; waitn(6);
    chk("R5 down ignored bcd", int'(c_bcd), 4);
    up = 1'b1; waitn(6);
    e_bcd = 5; e_bin = 5;
    chk_counts("R3 up after down");

    // R10: both strobes rise together
    up = 1'b0; dn = 1'b0; waitn(6);
    up = 1'b1; dn = 1'b1; waitn(6);
    chk("R10 both bcd", int'(c_bcd), 5);
    chk("R10 both bin", int'(c_bin), 5);

    // R2: load holds against counting
    load_val = 4'd3; load_n = 1'b0;
    up = 1'b0; waitn(6); up = 1'b1; waitn(6);
    chk("R2 load over count", int'(c_bcd), 3);
    chk("R2 load over count bin", int'(c_bin), 3);

    // R1: clear wins over load and counting, also clears upper digit
    load_val = 4'd7; clr = 1'b1;
    up = 1'b0; waitn(6); up = 1'b1; waitn(6);
    chk("R1 clear bcd", int'(c_bcd), 0);
    chk("R1 clear bin", int'(c_bin), 0);
    chk("R1 clear hi", int'(c_hi), 0);
    clr = 1'b0; load_n = 1'b1;
    waitn(3);
    chk("R1 after clear", int'(c_bcd), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule